// File: doc/BRIEF.md
# Glitch-free clock source switcher

This block picks the system clock from three free-running sources: a primary clock, an internal clock and a slow secondary clock. A 2-bit select field, written by software in the system clock domain, names the wanted source. The switched clock is gated so that a change of source never produces a runt pulse. The outgoing clock keeps driving the output until the incoming source reports ready. The output is then parked low while each domain confirms the handoff through its own synchronizer. It is released on a falling edge of the incoming clock.

Each source has its own gating cell with its own synchronizer and enable register, so every count of edges happens in that clock's domain. A small control stage clocked by the switched clock holds the target source. It raises a busy flag while a handoff is in progress, and it queues a select value that arrives during a handoff. The ready flags are taken as given. Oscillator start-up timing and failure monitoring are not part of the block.

Top module: `gf_clock_switch`

## Requirements
- R1: Select code 00 picks the primary clock, 10 the internal clock and 01 the secondary clock. After a switch completes, `clk_o` runs at the selected source's period. `src_on_o` bit 0 marks primary, bit 1 internal and bit 2 secondary as the source driving `clk_o`.
- R2: While `rst_ni` is low, `clk_o` stays low, `src_on_o` is 000 and the target returns to the primary clock. After release, the primary clock is switched in first, regardless of the select input.
- R3: At most one source is enabled at any time. An enable changes only while its own clock is low, so no high or low pulse on `clk_o` is shorter than the shorter half-period of the sources in use. Reset is the exception.
- R4: After a select change, the old source keeps driving `clk_o` for as long as the new source's ready flag is low.
- R5: Once the new source is ready, the old source is gated off at the first falling edge of the old clock that follows two old-clock rising edges. This gives exactly two more `clk_o` rising edges from the old source after ready rises.
- R6: With the output low, the new source is enabled at the falling edge that follows two new-clock rising edges. The low gap on `clk_o` therefore lasts between two and three new-clock periods.
- R7: `busy_o` goes high at the first `clk_o` rising edge after a select change. It stays high until the target source drives `clk_o`, and it is high whenever no source is enabled after reset.
- R8: A select value written while `busy_o` is high is stored. It is applied after the current switch completes, and `busy_o` stays high until that second switch completes.
- R9: Writing the code of the source already driving `clk_o` starts no switch: `busy_o` stays low and `clk_o` is not interrupted.
- R10: Select code 11 is reserved and ignored: no switch starts and `busy_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_pri_i | input | 1 | Primary source clock |
| clk_int_i | input | 1 | Internal source clock |
| clk_sec_i | input | 1 | Secondary low-speed source clock |
| rdy_pri_i | input | 1 | Primary source is stable |
| rdy_int_i | input | 1 | Internal source is stable |
| rdy_sec_i | input | 1 | Secondary source is stable |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 2 | Source select code, sampled on `clk_o` |
| clk_o | output | 1 | Switched system clock |
| busy_o | output | 1 | A source handoff is in progress or queued |
| src_on_o | output | 3 | One-hot0 flag of the source driving `clk_o` |

## Verification
The switching function is driven through a walk over every legal pair of sources, in both directions. The walk includes a repeat of the current code and the reserved code, so a real handoff, a no-operation and an ignored write can each be told apart by the presence of `busy_o` and of a pause. The three source clocks have unrelated periods and phases. This makes the measured low gap separate a handoff that waits the right number of new-clock edges from one that waits too few or too many, and the measured output period shows which source actually won. Directed cases hold the target's ready flag low to show the old clock is kept, then count the old-clock pulses after ready rises. They also write a second code during a handoff to show it is queued, and reset mid-run with a non-primary code still present to show that primary comes up first.

// File: rtl/gfcs_pkg.sv
`timescale 1ns/1ps
package gfcs_pkg;

  localparam int NUM_SRC = 3;
  localparam int SEL_W   = 2;
  localparam int IDX_W   = $clog2(NUM_SRC);

  typedef enum logic [IDX_W-1:0] {
    SRC_PRI = 2'd0,
    SRC_INT = 2'd1,
    SRC_SEC = 2'd2
  } src_e;

  typedef struct packed {
    logic ok;
    src_e idx;
  } sel_dec_t;

  // Code map: 00 primary, 10 internal, 01 secondary, 11 reserved.
  function automatic sel_dec_t decode_sel(input logic [SEL_W-1:0] code);
    sel_dec_t d;
    d.ok  = 1'b1;
    d.idx = SRC_PRI;
    case (code)
      2'b00:   d.idx = SRC_PRI;
      2'b10:   d.idx = SRC_INT;
      2'b01:   d.idx = SRC_SEC;
      default: d.ok  = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/gfcs_gate_cell.sv
`timescale 1ns/1ps
// One per source: synchronizes the on/off request into the source's own
// domain and moves the enable only on that clock's falling edge.
module gfcs_gate_cell #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic is_tgt_i,
  input  logic own_rdy_i,
  input  logic tgt_rdy_i,
  input  logic others_on_i,
  output logic en_o
);

  localparam int LAST = SYNC_STAGES - 1;

  logic             req;
  logic [LAST:0]    sync_q;

  // Turn on: this cell is the target, it is ready, nobody else drives.
  // Stay on: still the target, or the target is not ready yet.
  always_comb begin
    if (en_o) req = is_tgt_i | ~tgt_rdy_i;
    else      req = is_tgt_i & own_rdy_i & ~others_on_i;
  end

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= req;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[LAST-1:0], req};
      end
    end
  endgenerate

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_o <= 1'b0;
    else         en_o <= sync_q[LAST];
  end

endmodule

// File: rtl/gfcs_select_ctrl.sv
`timescale 1ns/1ps
// Target register and queue, clocked by the switched clock.
module gfcs_select_ctrl
  import gfcs_pkg::*;
(
  input  logic               sys_clk_i,
  input  logic               rst_ni,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [NUM_SRC-1:0] on_i,
  output src_e               tgt_o,
  output logic               busy_o
);

  sel_dec_t dec;
  logic     tgt_live;
  logic     pend_v;
  src_e     pend_q;

  always_comb begin
    dec      = decode_sel(sel_i);
    tgt_live = on_i[tgt_o];
  end

  always_ff @(posedge sys_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_o  <= SRC_PRI;
      pend_q <= SRC_PRI;
      pend_v <= 1'b0;
    end else if (tgt_live) begin
      if (pend_v) begin
        tgt_o  <= pend_q;
        pend_v <= 1'b0;
      end else if (dec.ok && dec.idx != tgt_o) begin
        tgt_o <= dec.idx;
      end
    end else if (dec.ok) begin
      if (dec.idx != tgt_o) begin
        pend_q <= dec.idx;
        pend_v <= 1'b1;
      end else begin
        pend_v <= 1'b0;
      end
    end
  end

  assign busy_o = ~tgt_live | pend_v;

endmodule

// File: rtl/gfcs_clk_merge.sv
`timescale 1ns/1ps
// AND-gates every source with its enable and ORs the results.
module gfcs_clk_merge #(
  parameter int N = 3
) (
  input  logic [N-1:0] clk_v,
  input  logic [N-1:0] en_v,
  output logic         clk_o
);

  logic [N-1:0] gated;

  generate
    for (genvar i = 0; i < N; i++) begin : g_gate
      assign gated[i] = clk_v[i] & en_v[i];
    end
  endgenerate

  assign clk_o = |gated;

endmodule

// File: rtl/gf_clock_switch.sv
`timescale 1ns/1ps
module gf_clock_switch
  import gfcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_pri_i,
  input  logic               clk_int_i,
  input  logic               clk_sec_i,
  input  logic               rdy_pri_i,
  input  logic               rdy_int_i,
  input  logic               rdy_sec_i,
  input  logic               rst_ni,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               clk_o,
  output logic               busy_o,
  output logic [NUM_SRC-1:0] src_on_o
);

  logic [NUM_SRC-1:0] clk_v;
  logic [NUM_SRC-1:0] rdy_v;
  logic [NUM_SRC-1:0] en_v;
  src_e               tgt_q;
  logic               tgt_rdy;

  assign clk_v   = {clk_sec_i, clk_int_i, clk_pri_i};
  assign rdy_v   = {rdy_sec_i, rdy_int_i, rdy_pri_i};
  assign tgt_rdy = rdy_v[tgt_q];

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic [NUM_SRC-1:0] mask;
      assign mask = ~(NUM_SRC'(1) << i);

      gfcs_gate_cell #(.SYNC_STAGES(SYNC_STAGES)) u_cell (
        .clk_i      (clk_v[i]),
        .rst_ni     (rst_ni),
        .is_tgt_i   (int'(tgt_q) == i),
        .own_rdy_i  (rdy_v[i]),
        .tgt_rdy_i  (tgt_rdy),
        .others_on_i(|(en_v & mask)),
        .en_o       (en_v[i])
      );
    end
  endgenerate

  gfcs_clk_merge #(.N(NUM_SRC)) u_merge (
    .clk_v(clk_v),
    .en_v (en_v),
    .clk_o(clk_o)
  );

  gfcs_select_ctrl u_ctrl (
    .sys_clk_i(clk_o),
    .rst_ni   (rst_ni),
    .sel_i    (sel_i),
    .on_i     (en_v),
    .tgt_o    (tgt_q),
    .busy_o   (busy_o)
  );

  assign src_on_o = en_v;

endmodule

// File: rtl/gfcs_chk.sv
`timescale 1ns/1ps
module gfcs_chk (
  input logic       clk_pri_i,
  input logic       clk_int_i,
  input logic       clk_sec_i,
  input logic       rst_ni,
  input logic       clk_o,
  input logic       busy_o,
  input logic [2:0] src_on_o,
  input logic [1:0] tgt_q
);

  AST_AT_MOST_ONE_SOURCE: assert property (@(posedge clk_pri_i) disable iff (!rst_ni)
    $onehot0(src_on_o)); // R3

  AST_HIGH_HAS_OWNER: assert property (@(posedge clk_o) disable iff (!rst_ni)
    $countones(src_on_o) == 1); // R3

  AST_OLD_DROPS_FOR_NEW: assert property (@(posedge clk_pri_i) disable iff (!rst_ni)
    $fell(src_on_o[0]) |-> (tgt_q != 2'd0)); // R4

  AST_GAP_IS_BUSY: assert property (@(posedge clk_pri_i) disable iff (!rst_ni)
    (src_on_o == 3'b000) |-> busy_o); // R7

  always @(src_on_o[0]) if (rst_ni) AST_GATE_LOW_PRI: assert (!clk_pri_i); // R3
  always @(src_on_o[1]) if (rst_ni) AST_GATE_LOW_INT: assert (!clk_int_i); // R3
  always @(src_on_o[2]) if (rst_ni) AST_GATE_LOW_SEC: assert (!clk_sec_i); // R3

  always @(posedge clk_pri_i)
    if (!rst_ni) AST_QUIET_IN_RESET: assert (src_on_o == 3'b000 && !clk_o); // R2

endmodule

bind gf_clock_switch gfcs_chk u_chk (
  .clk_pri_i(clk_pri_i),
  .clk_int_i(clk_int_i),
  .clk_sec_i(clk_sec_i),
  .rst_ni   (rst_ni),
  .clk_o    (clk_o),
  .busy_o   (busy_o),
  .src_on_o (src_on_o),
  .tgt_q    (tgt_q)
);

// File: tb/sim_gf_clock_switch.sv
`timescale 1ns/1ps
module sim_gf_clock_switch;

  localparam real HP_PRI = 4.0;   // 125 MHz primary
  localparam real HP_INT = 3.1;
  localparam real HP_SEC = 10.7;
  localparam real MINP   = HP_INT - 0.01;
  localparam real TOL    = 0.05;

  typedef struct packed {
    logic [1:0] sel;
    logic [2:0] on;
    logic       sw;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{2'b10, 3'b010, 1'b1},
    '{2'b01, 3'b100, 1'b1},
    '{2'b00, 3'b001, 1'b1},
    '{2'b01, 3'b100, 1'b1},
    '{2'b10, 3'b010, 1'b1},
    '{2'b10, 3'b010, 1'b0},
    '{2'b11, 3'b010, 1'b0},
    '{2'b00, 3'b001, 1'b1}
  };

  logic clk_pri = 1'b0, clk_int = 1'b0, clk_sec = 1'b0;
  logic rdy_pri = 1'b1, rdy_int = 1'b1, rdy_sec = 1'b1;
  logic rst_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic clk_o, busy_o;
  logic [2:0] src_on_o;

  int  checks = 0, fails = 0;
  bit  done = 1'b0;

  gf_clock_switch u0 (
    .clk_pri_i(clk_pri), .clk_int_i(clk_int), .clk_sec_i(clk_sec),
    .rdy_pri_i(rdy_pri), .rdy_int_i(rdy_int), .rdy_sec_i(rdy_sec),
    .rst_ni(rst_n), .sel_i(sel),
    .clk_o(clk_o), .busy_o(busy_o), .src_on_o(src_on_o)
  );

  always #(HP_PRI) clk_pri = ~clk_pri;
  initial begin #0.777; forever #(HP_INT) clk_int = ~clk_int; end
  initial begin #2.313; forever #(HP_SEC) clk_sec = ~clk_sec; end

  // Output pulse monitor
  bit  mon_on = 1'b0;
  real last_rise = -1.0, last_fall = -1.0, max_low = 0.0;
  int  n_rise = 0, short_cnt = 0;
  bit  busy_seen = 1'b0;

  always @(posedge clk_o) begin
    real w;
    if (mon_on && last_fall >= 0.0) begin
      w = $realtime - last_fall;
      if (w > max_low) max_low = w;
      if (w < MINP) short_cnt++;
    end
    last_rise = $realtime;
    n_rise++;
  end

  always @(negedge clk_o) begin
    real w;
    if (mon_on && last_rise >= 0.0) begin
      w = $realtime - last_rise;
      if (w < MINP) short_cnt++;
    end
    last_fall = $realtime;
  end

  always @(posedge busy_o) busy_seen = 1'b1;

  function automatic real per_of(input logic [2:0] on);
    case (on)
      3'b001:  return 2.0 * HP_PRI;
      3'b010:  return 2.0 * HP_INT;
      default: return 2.0 * HP_SEC;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0.3f expected=%0.3f", req, what, act, exp);
    end
  endtask

  task automatic wait_idle(input string req);
    for (int k = 0; k < 4000 && busy_o; k++) @(posedge clk_pri);
    #0.3;
    check(!busy_o, req, "busy clears", real'(busy_o), 0.0);
  endtask

  task automatic meas_period(output real p);
    real t0;
    @(posedge clk_o);
    t0 = $realtime;
    repeat (4) @(posedge clk_o);
    p = ($realtime - t0) / 4.0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    real p, tn, hold;
    int  r0;
    string tag;

    // Reset state (R2)
    #50;
    check(src_on_o == 3'b000, "R2", "src_on in reset", real'(src_on_o), 0.0);
    check(clk_o == 1'b0 && n_rise == 0, "R2", "clk_o quiet in reset", real'(n_rise), 0.0);
    rst_n = 1'b1;
    last_rise = -1.0; last_fall = -1.0; mon_on = 1'b1;
    wait_idle("R2");
    check(src_on_o == 3'b001, "R2", "primary after reset", real'(src_on_o), 1.0);
    meas_period(p);
    check(p > 8.0 - TOL && p < 8.0 + TOL, "R1", "primary period", p, 8.0);

    // Table walk: R1, R6, R7, R9, R10
    for (int k = 0; k < NV; k++) begin
      tn = per_of(VECS[k].on);
      @(negedge clk_o);
      max_low = 0.0; busy_seen = 1'b0;
      sel = VECS[k].sel;
      repeat (2) @(posedge clk_o);
      wait_idle("R7");
      check(src_on_o == VECS[k].on, "R1", "source flag", real'(src_on_o), real'(VECS[k].on));
      meas_period(p);
      check(p > tn - TOL && p < tn + TOL, "R1", "output period", p, tn);
      if (VECS[k].sw) begin
        check(busy_seen, "R7", "busy rose on switch", real'(busy_seen), 1.0);
        check(max_low > 2.0 * tn - 0.5 && max_low < 3.0 * tn + 0.5, "R6",
              "low gap", max_low, 2.5 * tn);
      end else begin
        tag = (VECS[k].sel == 2'b11) ? "R10" : "R9";
        check(!busy_seen, tag, "no busy", real'(busy_seen), 0.0);
        check(max_low < tn / 2.0 + TOL, tag, "no interruption", max_low, tn / 2.0);
      end
    end

    // R4: target not ready, old clock keeps running
    rdy_int = 1'b0;
    @(negedge clk_o); sel = 2'b10;
    repeat (40) @(posedge clk_pri);
    #0.3;
    check(src_on_o == 3'b001, "R4", "old source kept", real'(src_on_o), 1.0);
    check(busy_o, "R4", "busy while waiting", real'(busy_o), 1.0);
    meas_period(p);
    check(p > 8.0 - TOL && p < 8.0 + TOL, "R4", "old period kept", p, 8.0);

    // R5: exactly two more old pulses after ready rises
    @(negedge clk_pri); #1.0;
    rdy_int = 1'b1;
    r0 = n_rise;
    for (int k = 0; k < 200 && src_on_o[0]; k++) @(posedge clk_pri);
    check(n_rise - r0 == 2, "R5", "old pulses after ready", real'(n_rise - r0), 2.0);
    wait_idle("R5");
    check(src_on_o == 3'b010, "R5", "internal after handoff", real'(src_on_o), 2.0);

    // R8: second write during a handoff is queued
    @(negedge clk_o); sel = 2'b00;
    @(posedge clk_o); #0.5;
    check(busy_o, "R7", "busy at first edge after write", real'(busy_o), 1.0);
    @(negedge clk_o); sel = 2'b01;
    wait_idle("R8");
    check(src_on_o == 3'b100, "R8", "queued source applied", real'(src_on_o), 4.0);
    meas_period(p);
    hold = 2.0 * HP_SEC;
    check(p > hold - TOL && p < hold + TOL, "R8", "secondary period", p, hold);

    // R2: reset mid-run with a non-primary code still selected
    mon_on = 1'b0;
    #3.0; rst_n = 1'b0;
    #20.0;
    check(src_on_o == 3'b000 && clk_o == 1'b0, "R2", "quiet after mid-run reset",
          real'(src_on_o), 0.0);
    r0 = n_rise;
    #100.0;
    check(n_rise == r0, "R2", "no clk_o edges in reset", real'(n_rise - r0), 0.0);
    last_rise = -1.0; last_fall = -1.0;
    rst_n = 1'b1; mon_on = 1'b1;
    @(posedge clk_o); #0.5;
    check(src_on_o == 3'b001, "R2", "primary first after reset", real'(src_on_o), 1.0);
    wait_idle("R1");
    check(src_on_o == 3'b100, "R1", "held code applied after reset", real'(src_on_o), 4.0);

    // R3: no runt pulses seen outside reset
    check(short_cnt == 0, "R3", "short pulses", real'(short_cnt), 0.0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule